// File: doc/BRIEF.md
# Masked Interrupt Controller with Halt

This block gathers interrupt requests for a single CPU. Peripherals raise one-cycle pulses on a 32-bit request vector. Each pulse latches a pending flag, whatever the enable settings. Software sees three registers over a simple word bus: a per-source enable word, the pending-flag word and a master enable word. The flag word is acknowledged by writing ones. The controller drives a level IRQ to the CPU. It is asserted while bit 0 of the master enable word is set and some pending flag has its enable bit set.

A fourth bus location is a halt control byte. Writing a byte with bit 7 set parks the CPU, and the block shows this on `halt_o`. Only a fresh request on a source that is both individually enabled and master-enabled releases the halt. On that clock edge the flag is captured, the halt drops and the IRQ rises together. Flags that were already pending when the halt was written do not release it.

The source positions follow this system's assignment:

| Bits | Source |
|------|--------|
| 0 | frame blank |
| 1 | line blank |
| 2 | scanline compare |
| 3..6 | counter overflow 0..3 |
| 7 | serial port |
| 8..11 | block-copy engine 0..3 |
| 12 | keys |
| 13 | expansion slot |
| 16 | processor sync |
| 17 | outbound queue empty |
| 18 | inbound queue holds data |
| 19 | cartridge transfer complete |

Bits 14 and 15 are not implemented. The other upper bits are kept as generic sources.

Top module: `irq_halt_ctrl`

## Requirements
- R1: A request pulse on any implemented bit of `req_i` sets the matching flag at the next clock edge, regardless of the enable and master registers.
- R2: `irq_o` is high exactly when bit 0 of the master register is 1 and the AND of the flag and enable registers is nonzero. Only bit 0 of the master register is stored; its other bits read 0.
- R3: Bits 14 and 15 are not implemented. They never become set in the flag or enable register, and they always read 0.
- R4: A bus write to the halt address (3) whose data bit 7 is 1 sets `halt_o` at the next edge. A write to the halt address with bit 7 at 0 leaves `halt_o` unchanged.
- R5: While halted, a request on a bit that is enabled, with master bit 0 set, clears `halt_o` at the same edge that captures the flag, and `irq_o` is high after that edge. Requests on disabled bits, or any request while the master bit is 0, leave the block halted, although their flags are still set. Flags already pending when the halt is written do not release it.
- R6: Writing the flag address (1) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A request and a clear on the same bit in the same cycle leave that flag set.
- R7: After reset the enable, flag and master registers are 0, and `halt_o` and `irq_o` are low.
- R8: `irq_o` falls in the cycle after the pending bits are acknowledged, after their enable bits are cleared, or after master bit 0 is cleared.
- R9: Bus map: address 0 is the enable register, 1 the flag register, 2 the master register and 3 the halt control. Reads are combinational on `reg_addr_i`, and the halt address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Request pulses, one bit per source |
| reg_wr_i | input | 1 | Bus write strobe |
| reg_addr_i | input | 2 | Bus word address |
| reg_wdata_i | input | 32 | Bus write data |
| reg_rdata_o | output | 32 | Bus read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt to the CPU |
| halt_o | output | 1 | CPU halt request |

## Verification
Every piece of state reaches the ports within one cycle. A flag that is lost or stuck shows on the flag read-back in the cycle after the request or acknowledge. When its source is enabled and master-enabled, it also shows at once as a missing or stuck `irq_o`. A halt state that goes wrong shows on `halt_o` at the edge after the halt write or the waking request. The bench therefore checks the read-back and both outputs right after each relevant edge. It gives particular attention to simultaneous request and clear, non-waking requests, and requests on the reserved bits.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;
  localparam int unsigned SRC_W = 32;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_FLAGS  = 2'd1,
    REG_MASTER = 2'd2,
    REG_HALT   = 2'd3
  } reg_sel_e;

  typedef enum logic {
    CPU_RUN  = 1'b0,
    CPU_HALT = 1'b1
  } cpu_state_e;

  // bits 14 and 15 have no source
  localparam logic [SRC_W-1:0] VALID_MASK_DFLT = 32'hFFFF_3FFF;
  localparam int unsigned HALT_BIT_DFLT = 7;

  localparam int unsigned SRC_FRAME_BLANK = 0;
  localparam int unsigned SRC_LINE_BLANK  = 1;
  localparam int unsigned SRC_LINE_CMP    = 2;
  localparam int unsigned SRC_CNT0        = 3;
  localparam int unsigned SRC_SERIAL      = 7;
  localparam int unsigned SRC_COPY0       = 8;
  localparam int unsigned SRC_KEYS        = 12;
  localparam int unsigned SRC_SYNC        = 16;
  localparam int unsigned SRC_TXQ_EMPTY   = 17;
  localparam int unsigned SRC_RXQ_DATA    = 18;
  localparam int unsigned SRC_CART_DONE   = 19;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned     SRC_W      = 32,
  parameter logic [SRC_W-1:0] VALID_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] req_i,
  input  logic             clr_we_i,
  input  logic [SRC_W-1:0] clr_data_i,
  output logic [SRC_W-1:0] flag_o
);
  logic [SRC_W-1:0] flag_q;

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    logic clr_bit;
    assign clr_bit = clr_we_i & clr_data_i[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= VALID_MASK[i] & (req_i[i] | (flag_q[i] & ~clr_bit));
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned      SRC_W      = 32,
  parameter logic [SRC_W-1:0] VALID_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic             mst_we_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] enable_o,
  output logic             master_o
);
  logic [SRC_W-1:0] enable_q;
  logic             master_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      master_q <= 1'b0;
    end else begin
      if (en_we_i)  enable_q <= wdata_i & VALID_MASK;
      if (mst_we_i) master_q <= wdata_i[0];
    end
  end

  assign enable_o = enable_q;
  assign master_o = master_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned SRC_W = 32
) (
  input  logic [SRC_W-1:0] flag_i,
  input  logic [SRC_W-1:0] enable_i,
  input  logic             master_i,
  input  logic [SRC_W-1:0] req_i,
  output logic             irq_o,
  output logic             wake_o
);
  assign irq_o  = master_i & (|(flag_i & enable_i));
  // enable_i already excludes unimplemented bits
  assign wake_o = master_i & (|(req_i & enable_i));
endmodule

// File: rtl/irq_halt_fsm.sv
module irq_halt_fsm
  import irq_halt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_req_i,
  input  logic wake_i,
  output logic halt_o
);
  cpu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wake_i)          state_d = CPU_RUN;
    else if (halt_req_i) state_d = CPU_HALT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CPU_RUN;
    else         state_q <= state_d;
  end

  assign halt_o = (state_q == CPU_HALT);
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import irq_halt_pkg::*;
#(
  parameter int unsigned      HALT_BIT   = HALT_BIT_DFLT,
  parameter logic [SRC_W-1:0] VALID_MASK = VALID_MASK_DFLT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] req_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [SRC_W-1:0] reg_wdata_i,
  output logic [SRC_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             halt_o
);
  reg_sel_e         sel;
  logic             en_we, flag_we, mst_we, halt_we;
  logic [SRC_W-1:0] flag_q, enable_q;
  logic             master_q;
  logic             wake;

  assign sel     = reg_sel_e'(reg_addr_i);
  assign en_we   = reg_wr_i & (sel == REG_ENABLE);
  assign flag_we = reg_wr_i & (sel == REG_FLAGS);
  assign mst_we  = reg_wr_i & (sel == REG_MASTER);
  assign halt_we = reg_wr_i & (sel == REG_HALT) & reg_wdata_i[HALT_BIT];

  irq_flag_bank #(.SRC_W(SRC_W), .VALID_MASK(VALID_MASK)) u_flags (
    .clk_i, .rst_ni, .req_i,
    .clr_we_i  (flag_we),
    .clr_data_i(reg_wdata_i),
    .flag_o    (flag_q)
  );

  irq_cfg_regs #(.SRC_W(SRC_W), .VALID_MASK(VALID_MASK)) u_cfg (
    .clk_i, .rst_ni,
    .en_we_i (en_we),
    .mst_we_i(mst_we),
    .wdata_i (reg_wdata_i),
    .enable_o(enable_q),
    .master_o(master_q)
  );

  irq_gate #(.SRC_W(SRC_W)) u_gate (
    .flag_i  (flag_q),
    .enable_i(enable_q),
    .master_i(master_q),
    .req_i,
    .irq_o,
    .wake_o  (wake)
  );

  irq_halt_fsm u_halt (
    .clk_i, .rst_ni,
    .halt_req_i(halt_we),
    .wake_i    (wake),
    .halt_o
  );

  always_comb begin
    unique case (sel)
      REG_ENABLE: reg_rdata_o = enable_q;
      REG_FLAGS:  reg_rdata_o = flag_q;
      REG_MASTER: reg_rdata_o = {{(SRC_W-1){1'b0}}, master_q};
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_halt_chk.sv
module irq_halt_chk #(
  parameter int unsigned      SRC_W      = 32,
  parameter int unsigned      HALT_BIT   = 7,
  parameter logic [SRC_W-1:0] VALID_MASK = '1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SRC_W-1:0] req_i,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic [SRC_W-1:0] reg_wdata_i,
  input logic [SRC_W-1:0] flag_q,
  input logic [SRC_W-1:0] enable_q,
  input logic             master_q,
  input logic             irq_o,
  input logic             halt_o
);
  logic wake_c;
  assign wake_c = master_q && ((req_i & enable_q & VALID_MASK) != '0);

  assert_req_sets_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i & VALID_MASK) != '0) |=>
      ((flag_q & $past(req_i & VALID_MASK)) == $past(req_i & VALID_MASK)));

  assert_master_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_q |-> !irq_o);

  assert_irq_has_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flag_q & enable_q) != '0));

  assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q | enable_q) & ~VALID_MASK) == '0);

  assert_halt_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd3 && reg_wdata_i[HALT_BIT] && !wake_c) |=> halt_o);

  assert_halt_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && wake_c) |=> (!halt_o && irq_o));

  assert_halt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !wake_c) |=> halt_o);

  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd1) |=>
      ((flag_q & $past(reg_wdata_i & ~req_i)) == '0));

  assert_master_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd2 && !reg_wdata_i[0]) |=> !irq_o);
endmodule

bind irq_halt_ctrl irq_halt_chk #(
  .SRC_W(irq_halt_pkg::SRC_W), .HALT_BIT(HALT_BIT), .VALID_MASK(VALID_MASK)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .flag_q     (flag_q),
  .enable_q   (enable_q),
  .master_q   (master_q),
  .irq_o      (irq_o),
  .halt_o     (halt_o)
);

// File: tb/tb_irq_halt_ctrl.sv
module tb_irq_halt_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] req_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, halt_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [1:0] A_EN = 2'd0, A_FL = 2'd1, A_MS = 2'd2, A_HT = 2'd3;

  always #4 clk_i = ~clk_i;

  irq_halt_ctrl dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [31:0] r = '0);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; req_i = r;
    @(posedge clk_i); #1;
    reg_wr_i = 1'b0; req_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; #1;
    d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [31:0] r);
    @(negedge clk_i);
    req_i = r;
    @(posedge clk_i); #1;
    req_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_EN, d); check("R7 enable", d, 0);
    rd(A_FL, d); check("R7 flags", d, 0);
    rd(A_MS, d); check("R7 master", d, 0);
    check("R7 irq", {31'b0, irq_o}, 0);
    check("R7 halt", {31'b0, halt_o}, 0);
  endtask

  task automatic t_capture;
    logic [31:0] d;
    pulse(32'h0008_1009);
    rd(A_FL, d); check("R1 flags captured while disabled", d, 32'h0008_1009);
    check("R2 irq low, nothing enabled", {31'b0, irq_o}, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    pulse(32'h0000_C000);
    rd(A_FL, d); check("R3 reserved request ignored", d, 32'h0008_1009);
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); check("R3 enable reserved bits read 0", d, 32'hFFFF_3FFF);
    check("R2 irq low, master off", {31'b0, irq_o}, 0);
    wr(A_EN, 32'h0000_0008);
    rd(A_EN, d); check("R9 enable stored", d, 32'h0000_0008);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(A_MS, 32'hFFFF_FFFF);
    check("R2 irq high, master on and bit3 pending", {31'b0, irq_o}, 1);
    rd(A_MS, d); check("R2 master reads bit0 only", d, 1);
    rd(A_HT, d); check("R9 halt address reads 0", d, 0);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    wr(A_FL, 32'h0000_0008);
    rd(A_FL, d); check("R6 write-1 clears bit3", d, 32'h0008_1001);
    check("R8 irq drops after acknowledge", {31'b0, irq_o}, 0);
    wr(A_FL, 32'h0000_0000);
    rd(A_FL, d); check("R6 write-0 leaves flags", d, 32'h0008_1001);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    wr(A_FL, 32'h0000_1001, 32'h0000_0001);
    rd(A_FL, d); check("R6 request beats clear", d, 32'h0008_0001);
  endtask

  task automatic t_mask_drop;
    logic [31:0] d;
    wr(A_EN, 32'h0000_0001);
    check("R2 irq on enabled bit0", {31'b0, irq_o}, 1);
    wr(A_EN, 32'h0);
    check("R8 irq drops on mask", {31'b0, irq_o}, 0);
    wr(A_EN, 32'h0000_0001);
    wr(A_MS, 32'h0);
    check("R8 irq drops on master off", {31'b0, irq_o}, 0);
    wr(A_FL, 32'hFFFF_FFFF);
    rd(A_FL, d); check("R6 clear all", d, 0);
  endtask

  task automatic t_halt;
    logic [31:0] d;
    wr(A_HT, 32'h0000_007F);
    check("R4 bit7 clear no halt", {31'b0, halt_o}, 0);
    wr(A_HT, 32'h0000_0080);
    check("R4 halt entered", {31'b0, halt_o}, 1);
    pulse(32'h0000_1000);
    check("R5 disabled source keeps halt", {31'b0, halt_o}, 1);
    rd(A_FL, d); check("R5 disabled source flag set", d, 32'h0000_1000);
    pulse(32'h0000_0001);
    check("R5 master off keeps halt", {31'b0, halt_o}, 1);
    wr(A_EN, 32'h0000_0001);
    wr(A_MS, 32'h1);
    check("R5 pending flag does not wake", {31'b0, halt_o}, 1);
    check("R2 irq from pending bit0", {31'b0, irq_o}, 1);
    wr(A_FL, 32'hFFFF_FFFF);
    check("R8 irq low after clear", {31'b0, irq_o}, 0);
    wr(A_EN, 32'h0000_0010);
    pulse(32'h0000_0010);
    check("R5 wake clears halt", {31'b0, halt_o}, 0);
    check("R5 irq high at wake", {31'b0, irq_o}, 1);
    wr(A_HT, 32'h0000_0080, 32'h0000_0010);
    check("R5 wake beats halt write", {31'b0, halt_o}, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_capture();
    t_reserved();
    t_irq();
    t_ack();
    t_same_cycle();
    t_mask_drop();
    t_halt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule